// File: doc/BRIEF.md
# Presettable cascadable down counter

An eight-stage synchronous down counter with a single active-low terminal output. A build parameter picks the coding of the count register: either one plain binary value running from 255 down to 0, or two packed BCD decades running from 99 down to 00. The units digit sits in bits [3:0] and the tens digit in bits [7:4]. On every rising clock edge where counting is enabled, the register drops by one. After zero it wraps to the maximum count.

All controls are active low. The reset input `rst_ni` acts as an asynchronous clear, and it forces the maximum count rather than zero. An asynchronous preset loads the jam input at once. A synchronous preset loads the jam input on the next edge, even when counting is disabled. The zero output goes low only while the count is zero and counting is enabled. This lets counters be chained by feeding each stage's zero output into the count enable of the next, more significant stage.

Top module: `preset_down_counter`

## Requirements
- R1: While `rst_ni` is low, the count becomes the maximum at once, with no clock edge needed: 8'h99 in BCD mode and 8'hFF in binary mode. This holds whatever the other controls do.
- R2: While `apre_ni` is low and `rst_ni` is high, the count takes `jam_i` at once, with no clock edge needed.
- R3: With `cen_ni` low and both presets high, each rising clock edge lowers the count by one.
- R4: With `cen_ni` high and both presets high, the count holds across clock edges.
- R5: `zero_no` is low exactly when the count is zero and `cen_ni` is low, and high otherwise.
- R6: With `spre_ni` low at a rising edge, the count takes `jam_i` on that edge, whatever the level of `cen_ni`.
- R7: In binary mode, counting down from 8'h00 gives 8'hFF.
- R8: In BCD mode, a units digit of 0 becomes 9 and borrows one from the tens digit. Counting from 8'h00 gives 8'h99, and 8'h20 counts to 8'h19.
- R9: In BCD mode, jam values holding non-decimal digits (A to F) are loaded unchanged. Such a digit then decrements as a plain 4-bit value: 8'hAB gives 8'hAA, and 8'hF0 gives 8'hE9.
- R10: When one stage's `zero_no` drives the next stage's `cen_ni`, the upper stage decrements only on edges where the lower stage is at zero. The pair then counts down as one number across the stage boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear to maximum count, active low |
| cen_ni | input | 1 | Carry-in / count enable, active low |
| spre_ni | input | 1 | Synchronous preset enable, active low |
| apre_ni | input | 1 | Asynchronous preset enable, active low |
| jam_i | input | CNT_W | Preset value |
| count_o | output | CNT_W | Current count |
| zero_no | output | 1 | Zero detect / carry-out, active low |

## Verification
The bench builds the block in both codings: one instance with `BCD_MODE` set and one without. Both run under the same controls, so one stimulus shows how the two codings split at the decade borrow and at wrap-around. A further pair of BCD instances is chained through the zero output, which exercises a borrow that crosses the stage boundary. Loading non-decimal jam values into the BCD instance reaches the plain 4-bit decrement path.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } op_e;

  localparam int unsigned DIGIT_W = 4;
endpackage

// File: rtl/pdc_digit.sv
module pdc_digit
  import pdc_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               borrow_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               borrow_o
);
  always_comb begin
    digit_o  = digit_i;
    borrow_o = 1'b0;
    if (borrow_i) begin
      if (digit_i == '0) begin
        digit_o  = DIGIT_W'(9);
        borrow_o = 1'b1;
      end else begin
        // non-decimal digits take the plain 4-bit step
        digit_o = digit_i - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdc_step.sv
module pdc_step
  import pdc_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter bit          BCD_MODE = 1'b0
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] dec_o
);
  localparam int unsigned N_DEC = CNT_W / DIGIT_W;

  generate
    if (BCD_MODE) begin : g_bcd
      logic [N_DEC:0] borrow;
      assign borrow[0] = 1'b1;
      for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        pdc_digit u_digit (
          .digit_i  (cnt_i[g*DIGIT_W +: DIGIT_W]),
          .borrow_i (borrow[g]),
          .digit_o  (dec_o[g*DIGIT_W +: DIGIT_W]),
          .borrow_o (borrow[g+1])
        );
      end
    end else begin : g_bin
      assign dec_o = cnt_i - 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             cen_ni,
  input  logic             spre_ni,
  input  logic [CNT_W-1:0] jam_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dec_i,
  output logic [CNT_W-1:0] cnt_d_o
);
  op_e op;

  always_comb begin
    if (!spre_ni)     op = OP_LOAD;
    else if (!cen_ni) op = OP_COUNT;
    else              op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  cnt_d_o = jam_i;
      OP_COUNT: cnt_d_o = dec_i;
      default:  cnt_d_o = cnt_i;
    endcase
  end
endmodule

// File: rtl/pdc_zero.sv
module pdc_zero #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cen_ni,
  output logic             zero_no
);
  assign zero_no = ~((cnt_i == '0) & ~cen_ni);
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter
  import pdc_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter bit          BCD_MODE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_ni,
  input  logic             spre_ni,
  input  logic             apre_ni,
  input  logic [CNT_W-1:0] jam_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_no
);
  localparam int unsigned N_DEC = CNT_W / DIGIT_W;
  localparam logic [CNT_W-1:0] MAX_CNT =
    BCD_MODE ? CNT_W'({N_DEC{4'h9}}) : {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;

  pdc_step #(.CNT_W(CNT_W), .BCD_MODE(BCD_MODE)) u_step (
    .cnt_i (cnt_q),
    .dec_o (cnt_dec)
  );

  pdc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .cen_ni  (cen_ni),
    .spre_ni (spre_ni),
    .jam_i   (jam_i),
    .cnt_i   (cnt_q),
    .dec_i   (cnt_dec),
    .cnt_d_o (cnt_d)
  );

  // clear dominates async preset; both act without a clock
  always_ff @(posedge clk_i or negedge rst_ni or negedge apre_ni) begin
    if (!rst_ni)       cnt_q <= MAX_CNT;
    else if (!apre_ni) cnt_q <= jam_i;
    else               cnt_q <= cnt_d;
  end

  pdc_zero #(.CNT_W(CNT_W)) u_zero (
    .cnt_i   (cnt_q),
    .cen_ni  (cen_ni),
    .zero_no (zero_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter bit          BCD_MODE = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cen_ni,
  input logic             spre_ni,
  input logic             apre_ni,
  input logic [CNT_W-1:0] jam_i,
  input logic [CNT_W-1:0] count_o,
  input logic             zero_no
);
  localparam int unsigned N_DEC = CNT_W / 4;
  localparam logic [CNT_W-1:0] MAX_CNT =
    BCD_MODE ? CNT_W'({N_DEC{4'h9}}) : {CNT_W{1'b1}};

  AST_ZERO_WHEN_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !cen_ni) |-> !zero_no); // R5

  AST_ZERO_ONLY_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_no |-> (count_o == '0 && !cen_ni)); // R5

  AST_SYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spre_ni && apre_ni) |=> (!apre_ni || count_o == $past(jam_i))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_ni && spre_ni && apre_ni) |=> (!apre_ni || count_o == $past(count_o))); // R4

  AST_MOVES_ON_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && spre_ni && apre_ni) |=> (!apre_ni || count_o != $past(count_o))); // R3

  AST_WRAP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && spre_ni && apre_ni && count_o == '0) |=> (!apre_ni || count_o == MAX_CNT)); // R7
endmodule

bind preset_down_counter pdc_chk #(.CNT_W(CNT_W), .BCD_MODE(BCD_MODE)) u_pdc_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cen_ni  (cen_ni),
  .spre_ni (spre_ni),
  .apre_ni (apre_ni),
  .jam_i   (jam_i),
  .count_o (count_o),
  .zero_no (zero_no)
);

// File: tb/tb_preset_down_counter.sv
module tb_preset_down_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, cen_lo_n = 1'b1, spre_n = 1'b1, apre_n = 1'b1;
  logic [7:0] jam = 8'h00;
  logic [7:0] cnt_bcd, cnt_bin, cnt_lo, cnt_hi;
  logic z_bcd, z_bin, z_lo, z_hi;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preset_down_counter #(.CNT_W(8), .BCD_MODE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_n), .spre_ni(spre_n), .apre_ni(apre_n),
    .jam_i(jam), .count_o(cnt_bcd), .zero_no(z_bcd));

  preset_down_counter #(.CNT_W(8), .BCD_MODE(1'b0)) u_bin (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_n), .spre_ni(spre_n), .apre_ni(apre_n),
    .jam_i(jam), .count_o(cnt_bin), .zero_no(z_bin));

  preset_down_counter #(.CNT_W(8), .BCD_MODE(1'b1)) u_lo (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_lo_n), .spre_ni(spre_n), .apre_ni(apre_n),
    .jam_i(jam), .count_o(cnt_lo), .zero_no(z_lo));

  preset_down_counter #(.CNT_W(8), .BCD_MODE(1'b1)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(z_lo), .spre_ni(spre_n), .apre_ni(apre_n),
    .jam_i(jam), .count_o(cnt_hi), .zero_no(z_hi));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    @(negedge clk);
    check("R1 bcd clear", cnt_bcd, 8'h99);
    check("R1 bin clear", cnt_bin, 8'hFF);
    check("R5 zero idle", {7'd0, z_bcd}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 hold after clear", cnt_bin, 8'hFF);
  endtask

  task automatic t_async_preset();
    @(negedge clk);
    jam = 8'h37;
    apre_n = 1'b0;
    #1;
    check("R2 bcd async load", cnt_bcd, 8'h37);
    check("R2 bin async load", cnt_bin, 8'h37);
    rst_n = 1'b0;
    #1;
    check("R1 clear beats preset", cnt_bcd, 8'h99);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 preset after clear", cnt_bin, 8'h37);
    apre_n = 1'b1;
    @(negedge clk);
    check("R4 hold after preset", cnt_bcd, 8'h37);
  endtask

  task automatic t_count();
    jam = 8'h21;
    spre_n = 1'b0;
    @(negedge clk);
    check("R6 bcd sync load", cnt_bcd, 8'h21);
    check("R6 bin sync load", cnt_bin, 8'h21);
    spre_n = 1'b1;
    cen_n = 1'b0;
    @(negedge clk);
    check("R3 bcd dec", cnt_bcd, 8'h20);
    check("R3 bin dec", cnt_bin, 8'h20);
    @(negedge clk);
    check("R8 bcd borrow", cnt_bcd, 8'h19);
    check("R3 bin dec", cnt_bin, 8'h1F);
  endtask

  task automatic t_hold();
    cen_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R4 bcd hold", cnt_bcd, 8'h19);
    check("R4 bin hold", cnt_bin, 8'h1F);
  endtask

  task automatic t_sync_priority();
    jam = 8'h05;
    spre_n = 1'b0;
    @(negedge clk);
    check("R6 load while disabled", cnt_bin, 8'h05);
    jam = 8'h01;
    cen_n = 1'b0;
    @(negedge clk);
    check("R6 load beats count", cnt_bcd, 8'h01);
    check("R6 load beats count", cnt_bin, 8'h01);
  endtask

  task automatic t_zero_wrap();
    spre_n = 1'b1;
    @(negedge clk);
    check("R3 reach zero", cnt_bin, 8'h00);
    check("R5 zero low when armed", {7'd0, z_bcd}, 8'h00);
    check("R5 zero low when armed", {7'd0, z_bin}, 8'h00);
    cen_n = 1'b1;
    #1;
    check("R5 zero high when disabled", {7'd0, z_bcd}, 8'h01);
    @(negedge clk);
    check("R4 hold at zero", cnt_bcd, 8'h00);
    cen_n = 1'b0;
    @(negedge clk);
    check("R8 bcd wrap", cnt_bcd, 8'h99);
    check("R7 bin wrap", cnt_bin, 8'hFF);
    check("R5 zero high after wrap", {7'd0, z_bin}, 8'h01);
  endtask

  task automatic t_bad_bcd();
    cen_n = 1'b1;
    jam = 8'hAB;
    spre_n = 1'b0;
    @(negedge clk);
    check("R9 load invalid", cnt_bcd, 8'hAB);
    spre_n = 1'b1;
    cen_n = 1'b0;
    @(negedge clk);
    check("R9 invalid units dec", cnt_bcd, 8'hAA);
    cen_n = 1'b1;
    jam = 8'hF0;
    spre_n = 1'b0;
    @(negedge clk);
    spre_n = 1'b1;
    cen_n = 1'b0;
    @(negedge clk);
    check("R9 invalid tens borrow", cnt_bcd, 8'hE9);
    cen_n = 1'b1;
  endtask

  task automatic t_cascade();
    logic [7:0] exp_lo [4] = '{8'h01, 8'h00, 8'h99, 8'h98};
    logic [7:0] exp_hi [4] = '{8'h02, 8'h02, 8'h01, 8'h01};
    cen_lo_n = 1'b1;
    jam = 8'h02;
    spre_n = 1'b0;
    @(negedge clk);
    check("R10 chain lo load", cnt_lo, 8'h02);
    check("R10 chain hi load", cnt_hi, 8'h02);
    spre_n = 1'b1;
    cen_lo_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 chain lo", cnt_lo, exp_lo[i]);
      check("R10 chain hi", cnt_hi, exp_hi[i]);
      if (i == 1) check("R10 chain carry low", {7'd0, z_lo}, 8'h00);
    end
    cen_lo_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_async_preset();
    t_count();
    t_hold();
    t_sync_priority();
    t_zero_wrap();
    t_bad_bcd();
    t_cascade();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule